// File: doc/BRIEF.md
# Dependence-Steered FIFO Issue Unit

This unit issues instructions from a small set of in-order queues instead of one associative window. When an instruction arrives, the unit checks whether the instruction that writes one of its sources is still the newest entry of some queue. If so, the instruction joins that queue, directly behind the instruction it depends on. If not, it starts a fresh chain in an empty queue. Each queue ends up holding a chain of dependent operations. Only the oldest entry of each queue is tested for readiness, so no source tags are broadcast to every waiting entry.

Readiness comes from a one-bit-per-register scoreboard. A dispatched instruction marks its destination pending. A short operation marks its destination ready at the end of its issue cycle, so the next operation in the same chain can issue in the following cycle. A long operation, such as a load, leaves its destination pending until an outside completion names that register on the completion port. Every queue can issue one instruction in each cycle.

Top module: `dep_fifo_issue`

## Requirements
- R1: After reset every register is ready and every queue is empty: no issue output is valid and dispatch is accepted.
- R2: If the producer of source A is the newest entry of a non-empty queue, the instruction is appended to that queue. Otherwise, if the producer of source B is the newest entry of a queue, it is appended there.
- R3: If neither source's producer is the newest entry of any queue, the instruction goes to the empty queue with the lowest index.
- R4: `disp_ready` is 0 when the queue chosen by R2 already holds DEPTH entries, or when R3 applies and no queue is empty. A queue never holds more than DEPTH entries.
- R5: `disp_ready` is 0 while the destination register of the offered instruction is pending.
- R6: An accepted dispatch marks its destination register pending from the next cycle.
- R7: A queue issues only its oldest entry, only when both of its source registers are ready, and in dispatch order. It issues at most one entry per cycle.
- R8: A short instruction (`disp_long`=0) marks its destination ready at the clock edge that ends its issue cycle. A dependent entry that then becomes the head of the same queue issues in the next cycle.
- R9: A long instruction (`disp_long`=1) leaves its destination pending after issue. When `done_valid` names that register, it becomes ready at that edge, and heads waiting on it issue in the next cycle.
- R10: Queues are independent: heads of different queues may issue in the same cycle, and a blocked head delays no other queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Instruction offered for dispatch |
| disp_src_a | input | log2(NREG) | First source register |
| disp_src_b | input | log2(NREG) | Second source register |
| disp_dst | input | log2(NREG) | Destination register |
| disp_long | input | 1 | Result arrives through the completion port rather than at issue |
| disp_ready | output | 1 | Offered instruction is accepted at this edge |
| iss_valid | output | NQ | Per queue: its head issues this cycle |
| iss_src_a | output | NQ*log2(NREG) | Per queue: first source of the issuing head |
| iss_src_b | output | NQ*log2(NREG) | Per queue: second source of the issuing head |
| iss_dst | output | NQ*log2(NREG) | Per queue: destination of the issuing head |
| iss_long | output | NQ | Per queue: issuing head is a long instruction |
| done_valid | input | 1 | A long result has arrived |
| done_reg | input | log2(NREG) | Register whose long result arrived |

## Verification
The bench builds the unit with NQ=2, DEPTH=2 and NREG=8. With only two queues of two entries, a few long instructions fill one queue and block the other. The bench can then reach, within a handful of cycles, a full target queue, the case where no queue is empty, a pending destination and a head waiting on another queue. Releasing the long results one at a time shows back-to-back issue within a chain. Releasing one register that heads in both queues wait on shows two queues issuing in the same cycle.

// File: rtl/dep_fifo_issue.sv
module dep_fifo_issue #(
  parameter int NQ    = 4,
  parameter int DEPTH = 4,
  parameter int NREG  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disp_valid,
  input  logic [$clog2(NREG)-1:0] disp_src_a,
  input  logic [$clog2(NREG)-1:0] disp_src_b,
  input  logic [$clog2(NREG)-1:0] disp_dst,
  input  logic                 disp_long,
  output logic                 disp_ready,
  output logic [NQ-1:0]        iss_valid,
  output logic [NQ*$clog2(NREG)-1:0] iss_src_a,
  output logic [NQ*$clog2(NREG)-1:0] iss_src_b,
  output logic [NQ*$clog2(NREG)-1:0] iss_dst,
  output logic [NQ-1:0]        iss_long,
  input  logic                 done_valid,
  input  logic [$clog2(NREG)-1:0] done_reg
);
  localparam int RW = $clog2(NREG);
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [RW-1:0] mem_a [NQ][DEPTH];
  logic [RW-1:0] mem_b [NQ][DEPTH];
  logic [RW-1:0] mem_d [NQ][DEPTH];
  logic          mem_l [NQ][DEPTH];
  logic [PW-1:0] hd [NQ];
  logic [NQ-1:0][CW-1:0] cnt;
  logic [RW-1:0] tl [NQ];
  logic [NREG-1:0] rdy;

  logic [NQ-1:0] hr;
  logic          hit_a, hit_b, has_empty;
  logic [QW-1:0] qa, qb, qe, sel;
  logic [PW-1:0] wp;
  logic          push;

  for (genvar q = 0; q < NQ; q++) begin : g_head
    assign hr[q] = (cnt[q] != '0) && rdy[mem_a[q][hd[q]]] && rdy[mem_b[q][hd[q]]];
    assign iss_src_a[q*RW +: RW] = mem_a[q][hd[q]];
    assign iss_src_b[q*RW +: RW] = mem_b[q][hd[q]];
    assign iss_dst[q*RW +: RW]   = mem_d[q][hd[q]];
    assign iss_long[q]           = mem_l[q][hd[q]];
  end
  assign iss_valid = hr;

  always_comb begin
    hit_a = 1'b0; hit_b = 1'b0; has_empty = 1'b0;
    qa = '0; qb = '0; qe = '0;
    for (int q = NQ - 1; q >= 0; q--) begin
      if (cnt[q] != '0 && tl[q] == disp_src_a) begin hit_a = 1'b1; qa = QW'(q); end
      if (cnt[q] != '0 && tl[q] == disp_src_b) begin hit_b = 1'b1; qb = QW'(q); end
      if (cnt[q] == '0) begin has_empty = 1'b1; qe = QW'(q); end
    end
  end

  assign sel        = hit_a ? qa : (hit_b ? qb : qe);
  assign wp         = hd[sel] + PW'(cnt[sel]);
  assign disp_ready = (hit_a || hit_b || has_empty) && (cnt[sel] != CW'(DEPTH)) && rdy[disp_dst];
  assign push       = disp_valid && disp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy <= '1;
      for (int q = 0; q < NQ; q++) begin
        cnt[q] <= '0;
        hd[q]  <= '0;
      end
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (hr[q]) begin
          hd[q] <= hd[q] + PW'(1);
          if (!mem_l[q][hd[q]]) rdy[mem_d[q][hd[q]]] <= 1'b1;
        end
        cnt[q] <= cnt[q] - CW'(hr[q]) + CW'(push && sel == QW'(q));
      end
      if (done_valid) rdy[done_reg] <= 1'b1;
      if (push) rdy[disp_dst] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_a[sel][wp] <= disp_src_a;
      mem_b[sel][wp] <= disp_src_b;
      mem_d[sel][wp] <= disp_dst;
      mem_l[sel][wp] <= disp_long;
      tl[sel]        <= disp_dst;
    end
  end
endmodule

// File: rtl/dep_fifo_issue_chk.sv
module dep_fifo_issue_chk #(
  parameter int NQ    = 4,
  parameter int DEPTH = 4,
  parameter int NREG  = 16
) (
  input logic clk,
  input logic rst_n,
  input logic disp_valid,
  input logic [$clog2(NREG)-1:0] disp_dst,
  input logic disp_ready,
  input logic [NQ-1:0] iss_valid,
  input logic [NQ*$clog2(NREG)-1:0] iss_src_a,
  input logic [NQ*$clog2(NREG)-1:0] iss_src_b,
  input logic [NQ*$clog2(NREG)-1:0] iss_dst,
  input logic [NQ-1:0] iss_long,
  input logic done_valid,
  input logic [$clog2(NREG)-1:0] done_reg,
  input logic [NREG-1:0] rdy,
  input logic [NQ-1:0][$clog2(DEPTH+1)-1:0] cnt
);
  localparam int RW = $clog2(NREG);

  AST_STALL_PENDING_DST: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !rdy[disp_dst] |-> !disp_ready); // R5
  AST_DST_GOES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_ready |=> !rdy[$past(disp_dst)]); // R6
  AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !(disp_valid && disp_ready && disp_dst == done_reg) |=> rdy[$past(done_reg)]); // R9

  for (genvar q = 0; q < NQ; q++) begin : g_q
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[q] <= ($clog2(DEPTH+1))'(DEPTH)); // R4
    AST_ISSUE_SRCS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[q] |-> rdy[iss_src_a[q*RW +: RW]] && rdy[iss_src_b[q*RW +: RW]]); // R7
    AST_SHORT_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[q] && !iss_long[q] |=> rdy[$past(iss_dst[q*RW +: RW])]); // R8
  end
endmodule

bind dep_fifo_issue dep_fifo_issue_chk #(.NQ(NQ), .DEPTH(DEPTH), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_dst(disp_dst),
  .disp_ready(disp_ready), .iss_valid(iss_valid), .iss_src_a(iss_src_a),
  .iss_src_b(iss_src_b), .iss_dst(iss_dst), .iss_long(iss_long),
  .done_valid(done_valid), .done_reg(done_reg), .rdy(rdy), .cnt(cnt)
);

// File: tb/test_dep_fifo_issue.sv
module test_dep_fifo_issue;
  localparam int NQ = 2, DEPTH = 2, NREG = 8, RW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 1'b0, disp_long = 1'b0, disp_ready;
  logic [RW-1:0] disp_src_a = '0, disp_src_b = '0, disp_dst = '0, done_reg = '0;
  logic done_valid = 1'b0;
  logic [NQ-1:0] iss_valid, iss_long;
  logic [NQ*RW-1:0] iss_src_a, iss_src_b, iss_dst;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [3*RW:0] expq [NQ][$];

  always #5 clk = ~clk;

  dep_fifo_issue #(.NQ(NQ), .DEPTH(DEPTH), .NREG(NREG)) i_dep_fifo_issue (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input int a, input int b, input int d, input bit lng,
                      input int q, input bit exp_rdy, input string req);
    @(negedge clk);
    disp_valid = 1'b1; disp_src_a = RW'(a); disp_src_b = RW'(b);
    disp_dst = RW'(d); disp_long = lng;
    #1;
    chk(disp_ready == exp_rdy, req, "disp_ready", int'(disp_ready), int'(exp_rdy));
    if (disp_ready) expq[q].push_back({lng, RW'(a), RW'(b), RW'(d)});
    @(posedge clk);
    #1 disp_valid = 1'b0;
  endtask

  task automatic finish_result(input int r);
    done_valid = 1'b1; done_reg = RW'(r);
    @(posedge clk);
    #1 done_valid = 1'b0;
  endtask

  task automatic complete(input int r);
    @(negedge clk);
    finish_result(r);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        if (iss_valid[q]) begin
          logic [3*RW:0] got, exp;
          got = {iss_long[q], iss_src_a[q*RW +: RW], iss_src_b[q*RW +: RW], iss_dst[q*RW +: RW]};
          checks++;
          if (expq[q].size() == 0) begin
            errors++;
            $display("FAIL R7 queue %0d issued unexpected: actual %0h expected none", q, got);
          end else begin
            exp = expq[q].pop_front();
            if (got != exp) begin
              errors++;
              $display("FAIL R2/R3/R7 queue %0d issue: actual %0h expected %0h", q, got, exp);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(iss_valid == '0, "R1", "iss_valid after reset", int'(iss_valid), 0);
    chk(disp_ready == 1'b1, "R1", "disp_ready after reset", int'(disp_ready), 1);

    // Phase A: fill queue 0 behind a long producer, then block queue 1
    send(0, 0, 1, 1'b1, 0, 1'b1, "R3");   // empty queue 0
    send(1, 0, 2, 1'b0, 0, 1'b1, "R2");   // src A producer is tail of queue 0
    send(0, 2, 3, 1'b0, 0, 1'b1, "R2");   // src B producer is tail of queue 0
    send(3, 0, 4, 1'b0, 0, 1'b0, "R4");   // queue 0 full
    send(0, 0, 5, 1'b1, 1, 1'b1, "R3");   // lowest empty is queue 1
    send(5, 0, 6, 1'b0, 1, 1'b1, "R2");
    send(0, 0, 7, 1'b0, 0, 1'b0, "R4");   // no tail match, no empty queue
    send(6, 0, 2, 1'b0, 1, 1'b0, "R5");   // destination r2 still pending
    @(negedge clk); #1;
    chk(iss_valid == '0, "R9", "long results hold heads", int'(iss_valid), 0);

    finish_result(1);
    @(negedge clk); #1;
    chk(iss_valid == 2'b01, "R9", "issue after completion", int'(iss_valid), 1);
    chk(iss_dst[RW-1:0] == 3'd2, "R9", "first chain head", int'(iss_dst[RW-1:0]), 2);
    @(negedge clk); #1;
    chk(iss_valid == 2'b01, "R8", "back-to-back dependent", int'(iss_valid), 1);
    chk(iss_dst[RW-1:0] == 3'd3, "R8", "second chain entry", int'(iss_dst[RW-1:0]), 3);
    @(negedge clk); #1;
    chk(iss_valid == 2'b00, "R10", "queue 1 still blocked", int'(iss_valid), 0);
    complete(5);
    @(negedge clk); #1;
    chk(iss_valid == 2'b10, "R9", "queue 1 released", int'(iss_valid), 2);
    repeat (2) @(negedge clk);

    // Phase B: two heads waiting on one long result
    send(0, 0, 1, 1'b1, 0, 1'b1, "R3");
    send(1, 0, 2, 1'b0, 0, 1'b1, "R2");
    send(1, 1, 3, 1'b0, 1, 1'b1, "R3");   // producer r1 no longer a tail
    @(negedge clk); #1;
    chk(iss_valid == 2'b00, "R7", "heads wait on r1", int'(iss_valid), 0);
    finish_result(1);
    @(negedge clk); #1;
    chk(iss_valid == 2'b11, "R10", "parallel issue", int'(iss_valid), 3);
    repeat (3) @(negedge clk);
    #1;
    chk(expq[0].size() == 0, "R7", "queue 0 drained", expq[0].size(), 0);
    chk(expq[1].size() == 0, "R7", "queue 1 drained", expq[1].size(), 0);
    chk(iss_valid == '0, "R7", "idle at end", int'(iss_valid), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end
endmodule